// File: doc/BRIEF.md
# Shared interrupt line aggregator

This block merges level-sensitive interrupt requests from a set of device slots onto four shared interrupt lines. Each device has four request pins. Each pin is folded onto one of the four lines by a slot-based rotation. For a device that sits behind one or more bridges, the rotation is applied again at every bridge level until the pin reaches the root bus.

Every line keeps a counter of how many pins currently hold it asserted. The block stores the last level of every pin and updates a counter only when one of its pins changes level. The line output is high whenever its counter is non-zero. The counters are also brought out for debug readback.

The position of each device in the bus hierarchy is fixed by parameters. For each device and each level there is one 8-bit device/function index, and each device also has a depth.

Top module: `irq_line_merge`

## Requirements
- R1: Device d owns four request pins. Pin p of device d is input bit `pin_i[d*4+p]`, and each pin carries a level of 0 or 1.
- R2: If a pin's input level equals its stored level, no counter changes. A level held steady for any number of cycles leaves every counter unchanged.
- R3: When a pin goes from 0 to 1, the counter of its mapped line is incremented. When a pin goes from 1 to 0, that counter is decremented. The new count is visible on `cnt_o` one clock edge after the input changes.
- R4: Line l (`line_o[l]`) is 1 exactly when its counter is non-zero. This equals the logical OR of all pins mapped to line l, and the line changes in the same cycle as its counter.
- R5: At each hierarchy level the line index becomes (index + slot) mod 4, where the slot is bits [7:3] of that level's device/function index. The process starts from the pin number and runs from the device's own bus up to the root. With the default parameters the total rotation for devices 0, 1, 2 and 3 is 1, 2, 3 and 0.
- R6: When several pins change in the same cycle, each counter afterwards equals the number of asserted pins mapped to its line.
- R7: Reset clears all stored pin levels and all counters and deasserts every line. After reset is released, pins that are already high are counted as rises at the next edge.
- R8: A counter never exceeds the total number of pins. It never wraps, even when every pin folds onto one line.
- R9: Counter l occupies `cnt_o[l*CW +: CW]`, where CW = clog2(4*NUM_DEV+1). With the defaults CW is 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 4*NUM_DEV | Request level of every device pin |
| line_o | output | 4 | Shared interrupt line levels |
| cnt_o | output | 4*CW | Per-line assertion counters for debug |

## Verification
The hardest case to reach is a single cycle in which many pins from different devices and different hierarchy depths change together and fold onto one line. That line's counter must then step by more than one. The vector table includes a pattern in which one pin from each device lands on line 0, followed by an all-ones and an all-zeros step. These steps move every counter by several counts in one edge.

Reset is asserted while pins are held high. The bench then checks that the released block counts those pins as fresh rises.

// File: rtl/irq_line_merge.sv
module irq_line_merge #(
  parameter int NUM_DEV = 4,
  parameter int MAX_DEPTH = 2,
  parameter logic [NUM_DEV*MAX_DEPTH*8-1:0] DEV_PATH = 64'h1828_1800_0010_0008,
  parameter logic [NUM_DEV*4-1:0] DEV_DEPTH = 16'h2211,
  localparam int NUM_PINS = NUM_DEV * 4,
  localparam int NUM_LINES = 4,
  localparam int CW = $clog2(NUM_PINS + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_PINS-1:0]     pin_i,
  output logic [NUM_LINES-1:0]    line_o,
  output logic [NUM_LINES*CW-1:0] cnt_o
);

  function automatic logic [1:0] dev_rot(input int d);
    logic [1:0] r;
    r = 2'd0;
    for (int k = 0; k < MAX_DEPTH; k++)
      if (k < int'(DEV_DEPTH[d*4 +: 4]))
        r = r + DEV_PATH[(d*MAX_DEPTH+k)*8+3 +: 2];
    return r;
  endfunction

  logic [NUM_PINS-1:0] lvl_q;
  logic [NUM_PINS-1:0] rise, fall;
  logic [1:0]          pin_line [NUM_PINS];
  logic [CW-1:0]       cnt_q [NUM_LINES];
  logic [CW-1:0]       cnt_d [NUM_LINES];
  logic [CW-1:0]       up_n  [NUM_LINES];
  logic [CW-1:0]       dn_n  [NUM_LINES];

  assign rise = pin_i & ~lvl_q;
  assign fall = ~pin_i & lvl_q;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_map
    localparam logic [1:0] PIN_IDX = 2'(p % 4);
    localparam logic [1:0] ROT = dev_rot(p / 4);
    assign pin_line[p] = PIN_IDX + ROT;
  end

  always_comb begin
    for (int l = 0; l < NUM_LINES; l++) begin
      up_n[l] = '0;
      dn_n[l] = '0;
      for (int p = 0; p < NUM_PINS; p++) begin
        if (pin_line[p] == 2'(l)) begin
          up_n[l] = up_n[l] + CW'(rise[p]);
          dn_n[l] = dn_n[l] + CW'(fall[p]);
        end
      end
      cnt_d[l] = cnt_q[l] + up_n[l] - dn_n[l];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= '0;
      for (int l = 0; l < NUM_LINES; l++) cnt_q[l] <= '0;
    end else begin
      lvl_q <= pin_i;
      for (int l = 0; l < NUM_LINES; l++) cnt_q[l] <= cnt_d[l];
    end
  end

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    assign line_o[l] = |cnt_q[l];
    assign cnt_o[l*CW +: CW] = cnt_q[l];

    a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
      cnt_q[l] <= CW'(NUM_PINS));

    a_r3_rise_cause: assert property (@(posedge clk) disable iff (rst)
      $rose(line_o[l]) |-> $past(|rise));

    a_r3_fall_cause: assert property (@(posedge clk) disable iff (rst)
      $fell(line_o[l]) |-> $past(|fall));
  end

  a_r2_no_change: assert property (@(posedge clk) disable iff (rst)
    (pin_i == lvl_q) |=> $stable(cnt_o));

  a_r7_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (cnt_o == '0 && line_o == '0));

endmodule

// File: tb/irq_line_merge_tb_top.sv
module irq_line_merge_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NDEV = 4;
  localparam int CW = 5;
  localparam int NVEC = 9;

  localparam logic [15:0] VEC_PIN [NVEC] = '{
    16'h0000, 16'h0001, 16'h0003, 16'h0010, 16'h0100,
    16'h1000, 16'h1248, 16'hFFFF, 16'h0000};
  localparam logic [3:0] VEC_LINE [NVEC] = '{
    4'b0000, 4'b0010, 4'b0110, 4'b0100, 4'b1000,
    4'b0001, 4'b0001, 4'b1111, 4'b0000};

  logic clk = 0;
  logic rst = 1;
  logic [NDEV*4-1:0] pin_i = '0;
  logic [3:0] line_o;
  logic [4*CW-1:0] cnt_o;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_line_merge dut_i (.clk(clk), .rst(rst), .pin_i(pin_i), .line_o(line_o), .cnt_o(cnt_o));

  function automatic logic [4*CW-1:0] model_cnt(input logic [15:0] v);
    int rot [4] = '{1, 2, 3, 0};
    logic [CW-1:0] c [4];
    for (int l = 0; l < 4; l++) c[l] = '0;
    for (int d = 0; d < NDEV; d++)
      for (int p = 0; p < 4; p++)
        if (v[d*4+p]) c[(p + rot[d]) % 4] = c[(p + rot[d]) % 4] + 1'b1;
    return {c[3], c[2], c[1], c[0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] v);
    @(negedge clk) pin_i = v;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7 reset counters", 32'(cnt_o), 32'h0);
    check("R7 reset lines", 32'(line_o), 32'h0);
    rst = 0;

    for (int i = 0; i < NVEC; i++) begin
      step(VEC_PIN[i]);
      check("R5 R4 line map", 32'(line_o), 32'(VEC_LINE[i]));
      check("R3 R6 R9 counters", 32'(cnt_o), 32'(model_cnt(VEC_PIN[i])));
    end

    step(16'h0005);
    repeat (4) @(negedge clk);
    check("R2 steady levels", 32'(cnt_o), 32'(model_cnt(16'h0005)));
    check("R1 R5 d0 pins 0,2", 32'(line_o), 32'b1010);

    step(16'h0015);
    check("R3 rise increments", 32'(cnt_o[2*CW +: CW]), 32'd1);
    step(16'h0004);
    check("R3 fall decrements", 32'(cnt_o[2*CW +: CW]), 32'd0);
    check("R4 line low at zero", 32'(line_o), 32'b1000);

    step(16'h1248);
    check("R8 four on one line", 32'(cnt_o[0 +: CW]), 32'd4);
    step(16'hFFFF);
    step(16'h0000);
    check("R8 no wrap on full fall", 32'(cnt_o), 32'h0);

    @(negedge clk) pin_i = 16'h00F0;
    rst = 1;
    @(posedge clk);
    @(negedge clk);
    check("R7 reset with pins high", 32'(line_o), 32'h0);
    rst = 0;
    @(posedge clk);
    @(negedge clk);
    check("R7 rise after reset", 32'(cnt_o), 32'(model_cnt(16'h00F0)));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule